// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the configuration access path of a legacy multi-function PC I/O device. It sits on an 8-bit I/O bus and answers two addresses: an index port and a data port. Access starts out locked. Two writes of a key byte to the index port open it. Once open, a byte written to the index port picks a configuration register, and the data port then writes or reads that register. A lock byte written to the index port closes access again.

The register contents are brought out as a flat vector for a separate decoder, which turns them into function enables and base addresses. A one-cycle event carries the index of every accepted register write and the mask of the bits it changed. With this event, downstream logic can rebuild only the fields that actually moved. Only a narrow window of indices can be written, and a narrower window can be read back.

Top module: `sio_cfg_port`

## Requirements
- R1: After synchronous reset, access is locked, the current index is 0x00, register 0xA0 holds 0xFF, registers 0xA1 to 0xA5 hold 0x00, and `wr_pulse` is low. `cfg_regs` bits [8k+7:8k] hold register 0xA0+k.
- R2: While locked, each write of 0x33 to the index port (address 0x0398) advances an unlock count. Access opens after the second such write.
- R3: While locked, writes of any other byte to the index port and all writes to the data port (address 0x0399) are ignored. They change no register, produce no event, and leave a partial unlock count intact.
- R4: While open, a write of 0xCC to the index port clears the unlock count and relocks, so two more key writes are needed. Any other byte written to the index port becomes the current index.
- R5: While open, a data-port write updates the register at the current index only when the index lies in 0xA0 to 0xA5 inclusive. Writes at any other index are dropped and produce no event.
- R6: `io_rdata` is combinational. It shows the register at the current index only while `ior` is high, the address is 0x0399, access is open and the index is 0xA0 or 0xA1. In every other case it reads 0xFF.
- R7: In the cycle after each accepted register write, `wr_pulse` is high for one cycle. `wr_index` gives the register index and `wr_mask` gives the XOR of the old and new values, which is zero for a rewrite of the same value.
- R8: The current index survives a relock and a later unlock.
- R9: Address decoding compares all 16 address bits. Writes to any other address, including aliases such as 0x1398, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| iow | input | 1 | Write strobe, one cycle per write |
| ior | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| cfg_regs | output | 48 | Raw configuration registers 0xA0..0xA5, byte k = 0xA0+k |
| wr_pulse | output | 1 | Accepted-write event |
| wr_index | output | 8 | Index of the register written |
| wr_mask | output | 8 | Bits changed by that write |

## Verification
The checker watches several rules on every cycle. While locked, reads return 0xFF and the registers do not move. Writes to foreign addresses change nothing. The index changes only on index-port writes. A lock byte closes access. Every accepted write is followed by an event whose mask matches the change in `cfg_regs`, and an event never names an index outside the window. Other behaviour can only be shown by the bench's scenarios, because these rules depend on history: the two-write key, a partial count that survives stray writes, the need for two fresh keys after a relock, the index that persists across a relock, and the narrower readback window.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] mask;
  } wr_evt_t;
endpackage

// File: rtl/sio_cfg_unlock.sv
// Key counter: counts key bytes while closed, cleared by the lock byte while open.
module sio_cfg_unlock #(
  parameter logic [7:0] KEY       = 8'h33,
  parameter logic [7:0] LOCK      = 8'hCC,
  parameter int         KEY_COUNT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open
);
  localparam int CW = $clog2(KEY_COUNT + 1);

  logic [CW-1:0] cnt;

  assign open = (cnt == CW'(KEY_COUNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (idx_wr) begin
      if (!open && wdata == KEY) begin
        cnt <= cnt + 1'b1;
      end else if (open && wdata == LOCK) begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/sio_cfg_index.sv
// Current index register, loaded only while open and not by the lock byte.
module sio_cfg_index #(
  parameter logic [7:0] LOCK = 8'hCC
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic       open,
  input  logic [7:0] wdata,
  output logic [7:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= 8'h00;
    end else if (idx_wr && open && wdata != LOCK) begin
      idx <= wdata;
    end
  end
endmodule

// File: rtl/sio_cfg_regfile.sv
// Window of writable configuration registers plus the change event.
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] WIN_LO  = 8'hA0,
  parameter logic [7:0] WIN_HI  = 8'hA5,
  parameter logic [7:0] RST_IDX = 8'hA0,
  parameter logic [7:0] RST_VAL = 8'hFF,
  localparam int        NREG    = int'(WIN_HI) - int'(WIN_LO) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dat_wr,
  input  logic [7:0]      idx,
  input  logic [7:0]      wdata,
  output logic [NREG*8-1:0] regs,
  output logic            evt_vld,
  output wr_evt_t         evt
);
  logic [NREG-1:0] we;
  logic [7:0]      old_val;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [7:0] MY_IDX = 8'(int'(WIN_LO) + k);
    localparam logic [7:0] MY_RST = (MY_IDX == RST_IDX) ? RST_VAL : 8'h00;

    assign we[k] = dat_wr && (idx == MY_IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[k*8 +: 8] <= MY_RST;
      end else if (we[k]) begin
        regs[k*8 +: 8] <= wdata;
      end
    end
  end

  always_comb begin
    old_val = 8'h00;
    for (int k = 0; k < NREG; k++) begin
      if (we[k]) old_val = regs[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_vld <= 1'b0;
      evt     <= '0;
    end else begin
      evt_vld <= |we;
      if (|we) begin
        evt.idx  <= idx;
        evt.mask <= old_val ^ wdata;
      end
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] IDX_ADDR  = 16'h0398,
  parameter logic [15:0] DAT_ADDR  = 16'h0399,
  parameter logic [7:0]  KEY       = 8'h33,
  parameter logic [7:0]  LOCK      = 8'hCC,
  parameter int          KEY_COUNT = 2,
  parameter logic [7:0]  WIN_LO    = 8'hA0,
  parameter logic [7:0]  WIN_HI    = 8'hA5,
  parameter logic [7:0]  RD_HI     = 8'hA1,
  parameter logic [7:0]  RST_IDX   = 8'hA0,
  parameter logic [7:0]  RST_VAL   = 8'hFF,
  localparam int         NREG      = int'(WIN_HI) - int'(WIN_LO) + 1,
  localparam int         NRD       = int'(RD_HI) - int'(WIN_LO) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              iow,
  input  logic              ior,
  output logic [7:0]        io_rdata,
  output logic [NREG*8-1:0] cfg_regs,
  output logic              wr_pulse,
  output logic [7:0]        wr_index,
  output logic [7:0]        wr_mask
);
  logic       idx_wr;
  logic       dat_wr;
  logic       cfg_open;
  logic [7:0] cur_idx;
  wr_evt_t    evt;

  assign idx_wr = iow && (io_addr == IDX_ADDR);
  assign dat_wr = iow && (io_addr == DAT_ADDR) && cfg_open;

  sio_cfg_unlock #(.KEY(KEY), .LOCK(LOCK), .KEY_COUNT(KEY_COUNT)) u_unlock (
    .clk    (clk),
    .rst    (rst),
    .idx_wr (idx_wr),
    .wdata  (io_wdata),
    .open   (cfg_open)
  );

  sio_cfg_index #(.LOCK(LOCK)) u_index (
    .clk    (clk),
    .rst    (rst),
    .idx_wr (idx_wr),
    .open   (cfg_open),
    .wdata  (io_wdata),
    .idx    (cur_idx)
  );

  sio_cfg_regfile #(
    .WIN_LO  (WIN_LO),
    .WIN_HI  (WIN_HI),
    .RST_IDX (RST_IDX),
    .RST_VAL (RST_VAL)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .dat_wr  (dat_wr),
    .idx     (cur_idx),
    .wdata   (io_wdata),
    .regs    (cfg_regs),
    .evt_vld (wr_pulse),
    .evt     (evt)
  );

  assign wr_index = evt.idx;
  assign wr_mask  = evt.mask;

  always_comb begin
    io_rdata = 8'hFF;
    if (ior && cfg_open && io_addr == DAT_ADDR) begin
      for (int k = 0; k < NRD; k++) begin
        if (cur_idx == 8'(int'(WIN_LO) + k)) io_rdata = cfg_regs[k*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [15:0] IDX_ADDR = 16'h0398,
  parameter logic [15:0] DAT_ADDR = 16'h0399,
  parameter logic [7:0]  LOCK     = 8'hCC,
  parameter logic [7:0]  WIN_LO   = 8'hA0,
  parameter logic [7:0]  WIN_HI   = 8'hA5,
  localparam int         NREG     = int'(WIN_HI) - int'(WIN_LO) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       io_addr,
  input logic [7:0]        io_wdata,
  input logic              iow,
  input logic              ior,
  input logic [7:0]        io_rdata,
  input logic [NREG*8-1:0] cfg_regs,
  input logic              wr_pulse,
  input logic [7:0]        wr_index,
  input logic [7:0]        wr_mask,
  input logic              open,
  input logic [7:0]        idx
);
  function automatic logic [7:0] pick(input logic [NREG*8-1:0] v, input logic [7:0] i);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 0; k < NREG; k++) begin
      if (i == 8'(int'(WIN_LO) + k)) r = v[k*8 +: 8];
    end
    return r;
  endfunction

  p_locked_read_ff_r6: assert property (@(posedge clk) disable iff (rst)
    (!open && ior) |-> io_rdata == 8'hFF);

  p_locked_regs_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !open |=> $stable(cfg_regs));

  p_lock_byte_closes_r4: assert property (@(posedge clk) disable iff (rst)
    (open && iow && io_addr == IDX_ADDR && io_wdata == LOCK) |=> !open);

  p_event_follows_write_r7: assert property (@(posedge clk) disable iff (rst)
    (open && iow && io_addr == DAT_ADDR && idx >= WIN_LO && idx <= WIN_HI) |=> wr_pulse);

  p_event_mask_r7: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> wr_mask == (pick(cfg_regs, wr_index) ^ pick($past(cfg_regs), wr_index)));

  p_event_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> (wr_index >= WIN_LO && wr_index <= WIN_HI));

  p_index_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !(iow && io_addr == IDX_ADDR) |=> $stable(idx));

  p_foreign_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (iow && io_addr != IDX_ADDR && io_addr != DAT_ADDR) |=> ($stable(cfg_regs) && $stable(open) && !wr_pulse));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .IDX_ADDR (IDX_ADDR),
  .DAT_ADDR (DAT_ADDR),
  .LOCK     (LOCK),
  .WIN_LO   (WIN_LO),
  .WIN_HI   (WIN_HI)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_addr  (io_addr),
  .io_wdata (io_wdata),
  .iow      (iow),
  .ior      (ior),
  .io_rdata (io_rdata),
  .cfg_regs (cfg_regs),
  .wr_pulse (wr_pulse),
  .wr_index (wr_index),
  .wr_mask  (wr_mask),
  .open     (cfg_open),
  .idx      (cur_idx)
);

// File: tb/sio_cfg_port_tb.sv
`timescale 1ns/1ps
module sio_cfg_port_tb;
  localparam int NREG = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       io_addr = 16'h0;
  logic [7:0]        io_wdata = 8'h0;
  logic              iow = 1'b0;
  logic              ior = 1'b0;
  logic [7:0]        io_rdata;
  logic [NREG*8-1:0] cfg_regs;
  logic              wr_pulse;
  logic [7:0]        wr_index;
  logic [7:0]        wr_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model
  logic [7:0] m_reg [NREG];
  int         m_cnt = 0;
  logic [7:0] m_idx = 8'h00;
  logic [15:0] exp_q [$];

  always #4 clk = ~clk;

  sio_cfg_port u_dut (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .iow      (iow),
    .ior      (ior),
    .io_rdata (io_rdata),
    .cfg_regs (cfg_regs),
    .wr_pulse (wr_pulse),
    .wr_index (wr_index),
    .wr_mask  (wr_mask)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NREG; k++) m_reg[k] = (k == 0) ? 8'hFF : 8'h00;
    m_cnt = 0;
    m_idx = 8'h00;
  endtask

  // Driver: one write cycle, model update and expected event pushed.
  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    if (a == 16'h0398) begin
      if (m_cnt < 2) begin
        if (d == 8'h33) m_cnt++;
      end else if (d == 8'hCC) m_cnt = 0;
      else m_idx = d;
    end else if (a == 16'h0399 && m_cnt == 2 && m_idx >= 8'hA0 && m_idx <= 8'hA5) begin
      exp_q.push_back({m_idx, m_reg[m_idx - 8'hA0] ^ d});
      m_reg[m_idx - 8'hA0] = d;
    end
    io_addr = a; io_wdata = d; iow = 1'b1;
    @(negedge clk);
    iow = 1'b0;
  endtask

  task automatic io_rd(input string req, input logic [15:0] a);
    logic [7:0] e;
    @(negedge clk);
    io_addr = a; ior = 1'b1;
    #1;
    e = 8'hFF;
    if (a == 16'h0399 && m_cnt == 2 && (m_idx == 8'hA0 || m_idx == 8'hA1)) e = m_reg[m_idx - 8'hA0];
    chk(req, 64'(io_rdata), 64'(e));
    ior = 1'b0;
  endtask

  task automatic chk_regs(input string req);
    logic [NREG*8-1:0] e;
    for (int k = 0; k < NREG; k++) e[k*8 +: 8] = m_reg[k];
    chk(req, 64'(cfg_regs), 64'(e));
  endtask

  // Monitor: compares each event against the scoreboard queue.
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      if (wr_pulse) begin
        if (exp_q.size() == 0) chk("R7 unexpected event", {48'h0, wr_index, wr_mask}, 64'h0);
        else chk("R7 event", {48'h0, wr_index, wr_mask}, {48'h0, exp_q.pop_front()});
      end else if (exp_q.size() != 0) begin
        chk("R7 missing event", 64'h0, {48'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_regs("R1 reset regs");
    chk("R1 no event", 64'(wr_pulse), 64'h0);
    io_rd("R1 locked read", 16'h0399);

    // R3 locked writes ignored, partial count kept
    io_wr(16'h0399, 8'h55);
    chk_regs("R3 locked data write");
    io_wr(16'h0398, 8'h33);
    io_wr(16'h0398, 8'h12);
    io_wr(16'h0399, 8'h00);
    chk_regs("R3 after stray writes");
    // R9 alias does not count as key
    io_wr(16'h1398, 8'h33);
    io_wr(16'h0398, 8'hA1);   // still locked: ignored as index
    io_rd("R2 one key keeps lock", 16'h0399);
    io_wr(16'h0398, 8'h33);   // second key: open
    io_wr(16'h0398, 8'hA1);
    io_rd("R2 open read A1", 16'h0399);

    // R5 write the whole window
    for (int k = 0; k < NREG; k++) begin
      io_wr(16'h0398, 8'(8'hA0 + k));
      io_wr(16'h0399, 8'(8'h11 * (k + 1)));
    end
    chk_regs("R5 window writes");
    // R6 readback window
    for (int k = 0; k < NREG; k++) begin
      io_wr(16'h0398, 8'(8'hA0 + k));
      io_rd("R6 readback", 16'h0399);
    end
    io_rd("R6 index port read", 16'h0398);
    // R5 outside window
    io_wr(16'h0398, 8'h9F); io_wr(16'h0399, 8'h77);
    io_wr(16'h0398, 8'hA6); io_wr(16'h0399, 8'h77);
    chk_regs("R5 out of window dropped");
    // R7 same value, zero mask; then partial change
    io_wr(16'h0398, 8'hA1); io_wr(16'h0399, 8'h22);
    io_wr(16'h0399, 8'h2D);
    chk_regs("R7 regs after rewrite");
    // R9 data alias
    io_wr(16'h1399, 8'h00);
    chk_regs("R9 alias data write");

    // R4 relock
    io_wr(16'h0398, 8'hCC);
    io_rd("R4 relocked read", 16'h0399);
    io_wr(16'h0399, 8'h00);
    chk_regs("R4 locked data write");
    io_wr(16'h0398, 8'h33);
    io_rd("R4 one key after relock", 16'h0399);
    io_wr(16'h0398, 8'h33);
    io_rd("R8 index kept across relock", 16'h0399);
    io_wr(16'h0399, 8'h5A);
    chk_regs("R8 write lands at kept index");
    io_wr(16'h0398, 8'hA0);
    io_rd("R6 read A0", 16'h0399);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule